// File: doc/BRIEF.md
# SPI Command Engine with Byte Register Window

This block is a host-side SPI master controlled through eight byte-wide registers. Software first loads the bytes to send. These are an opcode byte, up to three address bytes and one optional trailing data byte. Software then writes a control word with the start bit set. The control word also chooses one of four outgoing frame shapes, a receive count from zero to three bytes, and an SCK rate. The engine reports busy and holds chip select low. It shifts the outgoing bytes out MSB first, then clocks in the requested response bytes and stores them in the receive registers. It then releases chip select, waits out a guard time and drops busy.

The register window has two quirks. The address bytes go onto the wire from the highest register offset down to the lowest. The top offset holds the trailing outgoing data byte, and the third received byte is also written there.

The sequencer has four states. `ST_IDLE` moves to `ST_XMIT` on a start pulse. `ST_XMIT` shifts the outgoing frame. After its last bit it moves to `ST_TAIL` when the receive count is zero, and to `ST_RECV` otherwise. `ST_RECV` clocks in the response and moves to `ST_TAIL` after its last bit. `ST_TAIL` keeps chip select high for one full SCK period and then returns to `ST_IDLE`.

Top module: `spi_cmd_engine`

## Requirements
- R1: Offset 0 reads as {busy, rate[1:0], 0, rcount[1:0], shape[1:0]}. Bit 7 is 1 from the cycle after a start write until the transfer has finished.
- R2: A write to offset 0 with bit 4 set starts a transfer. The stored control bits 6:5 (rate), 3:2 (rcount) and 1:0 (shape) are updated by that write, and bit 4 always reads back as 0.
- R3: The shape code gives the outgoing bytes, in wire order. Code 0 sends the opcode (offset 1) alone. Code 1 sends the opcode and then offset 7. Code 2 sends the opcode and then offsets 4, 3 and 2. Code 3 sends the opcode, offsets 4, 3 and 2, and then offset 7. Each byte goes out MSB first.
- R4: After the outgoing bytes, rcount bytes are received, each MSB first. They are stored at offsets 5, 6 and 7, in arrival order.
- R5: SPI mode 0 is used. SCK is low whenever chip select is high. MOSI changes only while SCK falls or is low. MISO is sampled on the rising edge of SCK.
- R6: Chip select goes low once per transfer and stays low from the first bit sent to the last bit received. One SCK pulse is given per bit.
- R7: Chip select is high for at least one SCK period (two half periods) before busy clears.
- R8: A write to offset 0 while busy is ignored. It starts nothing and leaves the stored control bits unchanged.
- R9: Offset 7 returns the last value written to it unless a third byte was received since then. In that case it returns the received byte.
- R10: The rate code sets the SCK half period in clock cycles, with B = HALF_BASE. Code 2'b10 gives B, 2'b11 gives 2B, 2'b00 gives 4B and 2'b01 gives 8B.
- R11: After reset, all registers read 0, chip select is high, and SCK and MOSI are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register offset |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for reg_addr, combinational |
| spi_sclk | output | 1 | Serial clock |
| spi_cs_n | output | 1 | Chip select, active low |
| spi_mosi | output | 1 | Serial data out |
| spi_miso | input | 1 | Serial data in |

## Verification
The bench builds the block with HALF_BASE = 1. With that value the fastest rate code gives an SCK half period of one clock, and the slowest gives eight. The bench can therefore measure the exact high time of SCK and the chip-select guard time for every rate code within a few dozen cycles. The slowest rate stretches a transfer long enough to land a second control write well inside the busy window.

// File: rtl/spi_cmd_pkg.sv
package spi_cmd_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_XMIT,
        ST_RECV,
        ST_TAIL
    } seq_state_t;

    localparam int FRAME_BYTES = 5;
    localparam int FRAME_BITS  = FRAME_BYTES * 8;

    // outgoing byte count for each shape code
    function automatic int shape_bytes(input logic [1:0] shape);
        case (shape)
            2'd0:    return 1;
            2'd1:    return 2;
            2'd2:    return 4;
            default: return 5;
        endcase
    endfunction

endpackage

// File: rtl/spi_cmd_clkdiv.sv
module spi_cmd_clkdiv #(
    parameter int HALF_BASE = 1
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       en,
    input  logic [1:0] rate,
    output logic       tick
);
    localparam int MAX_HALF = 8 * HALF_BASE;
    localparam int CW       = $clog2(MAX_HALF + 1);

    logic [CW-1:0] cnt_q;
    logic [CW-1:0] limit;

    always_comb begin
        unique case (rate)
            2'b10:   limit = CW'(HALF_BASE - 1);
            2'b11:   limit = CW'(2 * HALF_BASE - 1);
            2'b00:   limit = CW'(4 * HALF_BASE - 1);
            default: limit = CW'(8 * HALF_BASE - 1);
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)              cnt_q <= '0;
        else if (!en)            cnt_q <= '0;
        else if (cnt_q == limit) cnt_q <= '0;
        else                     cnt_q <= cnt_q + 1'b1;
    end

    assign tick = en && (cnt_q == limit);
endmodule

// File: rtl/spi_cmd_regs.sv
module spi_cmd_regs (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       we,
    input  logic [2:0] addr,
    input  logic [7:0] wdata,
    output logic [7:0] rdata,
    input  logic       busy,
    output logic       start,
    output logic [6:0] ctrl,
    output logic [7:0] opcode,
    output logic [7:0] adr_hi,
    output logic [7:0] adr_mid,
    output logic [7:0] adr_lo,
    output logic [7:0] shared,
    input  logic       cap_valid,
    input  logic [1:0] cap_idx,
    input  logic [7:0] cap_byte
);
    logic [6:0] ctrl_q;
    logic [7:0] op_q, hi_q, mid_q, lo_q, rx0_q, rx1_q, sh_q;
    logic       start_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q  <= '0;
            op_q    <= '0;
            hi_q    <= '0;
            mid_q   <= '0;
            lo_q    <= '0;
            rx0_q   <= '0;
            rx1_q   <= '0;
            sh_q    <= '0;
            start_q <= 1'b0;
        end else begin
            start_q <= 1'b0;
            if (we) begin
                unique case (addr)
                    3'd0: if (!busy) begin
                        ctrl_q  <= {wdata[6:5], 1'b0, wdata[3:0]};
                        start_q <= wdata[4];
                    end
                    3'd1: op_q  <= wdata;
                    3'd2: lo_q  <= wdata;
                    3'd3: mid_q <= wdata;
                    3'd4: hi_q  <= wdata;
                    3'd7: sh_q  <= wdata;
                    default: ;
                endcase
            end
            if (cap_valid) begin
                unique case (cap_idx)
                    2'd0:    rx0_q <= cap_byte;
                    2'd1:    rx1_q <= cap_byte;
                    default: sh_q  <= cap_byte;
                endcase
            end
        end
    end

    always_comb begin
        unique case (addr)
            3'd0:    rdata = {busy, ctrl_q};
            3'd1:    rdata = op_q;
            3'd2:    rdata = lo_q;
            3'd3:    rdata = mid_q;
            3'd4:    rdata = hi_q;
            3'd5:    rdata = rx0_q;
            3'd6:    rdata = rx1_q;
            default: rdata = sh_q;
        endcase
    end

    assign start   = start_q;
    assign ctrl    = ctrl_q;
    assign opcode  = op_q;
    assign adr_hi  = hi_q;
    assign adr_mid = mid_q;
    assign adr_lo  = lo_q;
    assign shared  = sh_q;
endmodule

// File: rtl/spi_cmd_seq.sv
module spi_cmd_seq
    import spi_cmd_pkg::*;
#(
    parameter int HALF_BASE = 1
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic [6:0] ctrl,
    input  logic [7:0] opcode,
    input  logic [7:0] adr_hi,
    input  logic [7:0] adr_mid,
    input  logic [7:0] adr_lo,
    input  logic [7:0] shared,
    input  logic       miso,
    output logic       sclk,
    output logic       cs_n,
    output logic       mosi,
    output logic       busy,
    output logic       cap_valid,
    output logic [1:0] cap_idx,
    output logic [7:0] cap_byte
);
    localparam int BCW = $clog2(FRAME_BITS + 1);

    seq_state_t            state_q, state_d;
    logic                  ph_q;
    logic [BCW-1:0]        bit_q, ntx_q;
    logic [FRAME_BITS-1:0] tx_q, frame;
    logic [7:0]            rx_q;
    logic [1:0]            rcnt_q, rate_q, rxb_q;
    logic                  tick, last_tx, last_rx;

    spi_cmd_clkdiv #(.HALF_BASE(HALF_BASE)) u_div (
        .clk  (clk),
        .rst_n(rst_n),
        .en   (state_q != ST_IDLE),
        .rate (rate_q),
        .tick (tick)
    );

    always_comb begin
        unique case (ctrl[1:0])
            2'd0:    frame = {opcode, 32'h0};
            2'd1:    frame = {opcode, shared, 24'h0};
            2'd2:    frame = {opcode, adr_hi, adr_mid, adr_lo, 8'h0};
            default: frame = {opcode, adr_hi, adr_mid, adr_lo, shared};
        endcase
    end

    assign last_tx = (bit_q == ntx_q - 1'b1);
    assign last_rx = (bit_q == BCW'({rcnt_q, 3'b000}) - 1'b1);

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (start) state_d = ST_XMIT;
            ST_XMIT: if (tick && ph_q && last_tx)
                         state_d = (rcnt_q == 2'd0) ? ST_TAIL : ST_RECV;
            ST_RECV: if (tick && ph_q && last_rx) state_d = ST_TAIL;
            ST_TAIL: if (tick && ph_q) state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // shift datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ph_q   <= 1'b0;
            bit_q  <= '0;
            ntx_q  <= '0;
            tx_q   <= '0;
            rx_q   <= '0;
            rcnt_q <= '0;
            rate_q <= '0;
            rxb_q  <= '0;
        end else if (state_q == ST_IDLE) begin
            ph_q  <= 1'b0;
            bit_q <= '0;
            rxb_q <= '0;
            if (start) begin
                tx_q   <= frame;
                ntx_q  <= BCW'(8 * shape_bytes(ctrl[1:0]));
                rcnt_q <= ctrl[3:2];
                rate_q <= ctrl[6:5];
            end
        end else if (tick) begin
            ph_q <= ~ph_q;
            if (!ph_q && state_q == ST_RECV)
                rx_q <= {rx_q[6:0], miso};
            if (ph_q) begin
                unique case (state_q)
                    ST_XMIT: begin
                        tx_q  <= {tx_q[FRAME_BITS-2:0], 1'b0};
                        bit_q <= last_tx ? '0 : bit_q + 1'b1;
                    end
                    ST_RECV: begin
                        bit_q <= bit_q + 1'b1;
                        if (bit_q[2:0] == 3'd7) rxb_q <= rxb_q + 1'b1;
                    end
                    default: ;
                endcase
            end
        end
    end

    // outputs
    always_comb begin
        cs_n      = !(state_q == ST_XMIT || state_q == ST_RECV);
        sclk      = ph_q && !cs_n;
        mosi      = (state_q == ST_XMIT) ? tx_q[FRAME_BITS-1] : 1'b0;
        busy      = (state_q != ST_IDLE);
        cap_valid = tick && ph_q && (state_q == ST_RECV) && (bit_q[2:0] == 3'd7);
        cap_idx   = rxb_q;
        cap_byte  = rx_q;
    end
endmodule

// File: rtl/spi_cmd_engine.sv
module spi_cmd_engine #(
    parameter int HALF_BASE = 1
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       reg_we,
    input  logic [2:0] reg_addr,
    input  logic [7:0] reg_wdata,
    output logic [7:0] reg_rdata,
    output logic       spi_sclk,
    output logic       spi_cs_n,
    output logic       spi_mosi,
    input  logic       spi_miso
);
    logic       start_w, seq_busy, busy_all, cap_valid;
    logic [1:0] cap_idx;
    logic [7:0] cap_byte, op_w, hi_w, mid_w, lo_w, sh_w;
    logic [6:0] ctrl_w;

    assign busy_all = seq_busy | start_w;

    spi_cmd_regs u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .we       (reg_we),
        .addr     (reg_addr),
        .wdata    (reg_wdata),
        .rdata    (reg_rdata),
        .busy     (busy_all),
        .start    (start_w),
        .ctrl     (ctrl_w),
        .opcode   (op_w),
        .adr_hi   (hi_w),
        .adr_mid  (mid_w),
        .adr_lo   (lo_w),
        .shared   (sh_w),
        .cap_valid(cap_valid),
        .cap_idx  (cap_idx),
        .cap_byte (cap_byte)
    );

    spi_cmd_seq #(.HALF_BASE(HALF_BASE)) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start_w),
        .ctrl     (ctrl_w),
        .opcode   (op_w),
        .adr_hi   (hi_w),
        .adr_mid  (mid_w),
        .adr_lo   (lo_w),
        .shared   (sh_w),
        .miso     (spi_miso),
        .sclk     (spi_sclk),
        .cs_n     (spi_cs_n),
        .mosi     (spi_mosi),
        .busy     (seq_busy),
        .cap_valid(cap_valid),
        .cap_idx  (cap_idx),
        .cap_byte (cap_byte)
    );
endmodule

// File: rtl/spi_cmd_engine_chk.sv
module spi_cmd_engine_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       we,
    input logic [2:0] addr,
    input logic       busy,
    input logic [6:0] ctrl,
    input logic       cs_n,
    input logic       sclk,
    input logic       mosi,
    input logic       cap_valid,
    input logic [1:0] cap_idx
);
    p_sclk_low_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |-> !sclk);

    p_mosi_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_n && sclk && $past(sclk)) |-> $stable(mosi));

    p_cs_within_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_n |-> busy);

    p_guard_before_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (cs_n && $past(cs_n) && $past(cs_n, 2)));

    p_ctrl_ignored_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && we && addr == 3'd0) |=> $stable(ctrl));

    p_capture_slot_r4: assert property (@(posedge clk) disable iff (!rst_n)
        cap_valid |-> (cap_idx != 2'd3 && !cs_n));
endmodule

bind spi_cmd_engine spi_cmd_engine_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .we       (reg_we),
    .addr     (reg_addr),
    .busy     (busy_all),
    .ctrl     (ctrl_w),
    .cs_n     (spi_cs_n),
    .sclk     (spi_sclk),
    .mosi     (spi_mosi),
    .cap_valid(cap_valid),
    .cap_idx  (cap_idx)
);

// File: tb/spi_cmd_engine_tb.sv
`timescale 1ns/1ps
module spi_cmd_engine_tb;
    localparam int HB = 1;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_we = 1'b0;
    logic [2:0] reg_addr = '0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic       spi_sclk, spi_cs_n, spi_mosi;
    logic       spi_miso = 1'b0;

    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;

    // slave model state
    logic [63:0] mosi_log;
    int          rises;
    int          tx_bits;
    logic [23:0] resp;
    int          cs_falls;
    time         t_rise;
    time         hi_ns;

    always #5 clk = ~clk;

    spi_cmd_engine #(.HALF_BASE(HB)) u_dut (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .spi_sclk(spi_sclk),
        .spi_cs_n(spi_cs_n), .spi_mosi(spi_mosi), .spi_miso(spi_miso)
    );

    always @(posedge spi_sclk) begin
        mosi_log = {mosi_log[62:0], spi_mosi};
        rises    = rises + 1;
        t_rise   = $time;
    end

    always @(negedge spi_sclk) begin
        int k;
        hi_ns = $time - t_rise;
        k = rises - tx_bits;
        if (k >= 0 && k < 24) spi_miso = resp[23-k];
    end

    always @(negedge spi_cs_n) cs_falls = cs_falls + 1;

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc = cyc + 1;
        if (cyc > 150000) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual %0d cycles, expected fewer", cyc);
            summary();
        end
    end

    task automatic check(string req, logic [63:0] act, logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wr(logic [2:0] a, logic [7:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0; reg_addr = 3'd0;
    endtask

    task automatic rd(logic [2:0] a, output logic [7:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
        reg_addr = 3'd0;
    endtask

    function automatic int half(logic [1:0] r);
        case (r)
            2'b10:   return HB;
            2'b11:   return 2 * HB;
            2'b00:   return 4 * HB;
            default: return 8 * HB;
        endcase
    endfunction

    function automatic int nbytes(logic [1:0] s);
        case (s)
            2'd0: return 1;
            2'd1: return 2;
            2'd2: return 4;
            default: return 5;
        endcase
    endfunction

    // wait for busy to drop; returns guard cycles between cs_n rising and busy clearing
    task automatic wait_idle(output int gap);
        int  rose_at = 0;
        logic prev_cs = 1'b0;
        gap = 0;
        for (int n = 0; n < 2000; n++) begin
            @(negedge clk);
            reg_addr = 3'd0;
            #1;
            if (!prev_cs && spi_cs_n) rose_at = n;
            prev_cs = spi_cs_n;
            if (!reg_rdata[7]) begin
                gap = n - rose_at;
                break;
            end
        end
    endtask

    task automatic run_xfer(string tag, logic [1:0] shape, logic [1:0] rc,
                            logic [1:0] rate, logic [7:0] op, logic [7:0] ah,
                            logic [7:0] am, logic [7:0] al, logic [7:0] dat,
                            logic [23:0] rsp);
        logic [39:0] frame;
        logic [63:0] mask, expv;
        logic [7:0]  d;
        int          nb, bits, gap;
        wr(3'd1, op); wr(3'd4, ah); wr(3'd3, am); wr(3'd2, al); wr(3'd7, dat);
        nb = nbytes(shape);
        case (shape)
            2'd0: frame = {op, 32'h0};
            2'd1: frame = {op, dat, 24'h0};
            2'd2: frame = {op, ah, am, al, 8'h0};
            default: frame = {op, ah, am, al, dat};
        endcase
        resp = rsp; tx_bits = nb * 8; rises = 0; mosi_log = '0; cs_falls = 0;
        wr(3'd0, {1'b0, rate, 1'b1, rc, shape});
        #1 check({"R1 busy set ", tag}, 64'(reg_rdata[7]), 64'd1);
        wait_idle(gap);
        bits = (nb + int'(rc)) * 8;
        check({"R6 sck pulses ", tag}, 64'(rises), 64'(bits));
        check({"R6 single cs window ", tag}, 64'(cs_falls), 64'd1);
        mask = (bits == 64) ? '1 : ((64'd1 << bits) - 64'd1);
        expv = (64'(frame >> (40 - nb * 8))) << (int'(rc) * 8);
        check({"R3 mosi bytes ", tag}, mosi_log & mask, expv & mask);
        check({"R10 sck high time ", tag}, 64'(hi_ns), 64'(half(rate) * 10));
        n_chk++;
        if (gap < 2 * half(rate)) begin
            n_bad++;
            $display("FAIL R7 guard %s: actual %0d expected >= %0d", tag, gap, 2 * half(rate));
        end
        rd(3'd0, d);
        check({"R2 ctrl readback ", tag}, 64'(d), 64'({1'b0, rate, 1'b0, rc, shape}));
        for (int k = 0; k < int'(rc); k++) begin
            rd(3'(5 + k), d);
            check({"R4 rx byte ", tag}, 64'(d), 64'(rsp[23 - 8*k -: 8]));
        end
        rd(3'd7, d);
        check({"R9 shared offset ", tag}, 64'(d), 64'((rc == 2'd3) ? rsp[7:0] : dat));
        check({"R5 idle levels ", tag}, 64'({spi_cs_n, spi_sclk}), 64'b10);
    endtask

    task automatic t_reset();
        logic [7:0] d;
        for (int a = 0; a < 8; a++) begin
            rd(3'(a), d);
            check("R11 reset register", 64'(d), 64'd0);
        end
        check("R11 reset pins", 64'({spi_cs_n, spi_sclk, spi_mosi}), 64'b100);
    endtask

    task automatic t_busy_write();
        logic [7:0] d;
        int gap;
        wr(3'd1, 8'h3C);
        tx_bits = 40; resp = 24'h0; rises = 0; cs_falls = 0;
        wr(3'd0, 8'h3B);          // rate 01, start, rcount 2, shape 3
        wr(3'd0, 8'h50);          // second start while busy
        rd(3'd0, d);
        check("R8 ctrl unchanged during busy", 64'(d), 64'h80 | 64'h2B);
        wait_idle(gap);
        check("R8 one cs window", 64'(cs_falls), 64'd1);
        rd(3'd0, d);
        check("R8 ctrl after busy", 64'(d), 64'h2B);
        repeat (40) @(negedge clk);
        check("R8 no second transfer", 64'({spi_cs_n, 1'(cs_falls)}), 64'b11);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        run_xfer("shape0 rx3", 2'd0, 2'd3, 2'b10, 8'h9F, 8'h00, 8'h00, 8'h00, 8'h11, 24'hA1B2C3);
        run_xfer("shape1 rx0", 2'd1, 2'd0, 2'b11, 8'h06, 8'h00, 8'h00, 8'h00, 8'h5A, 24'h0);
        run_xfer("shape2 rx1", 2'd2, 2'd1, 2'b00, 8'h03, 8'h12, 8'h34, 8'h56, 8'hEE, 24'h7E0000);
        run_xfer("shape3 rx2", 2'd3, 2'd2, 2'b01, 8'h02, 8'hAB, 8'hCD, 8'hEF, 8'hC5, 24'h800100);
        run_xfer("shape3 rx3", 2'd3, 2'd3, 2'b10, 8'hD4, 8'h81, 8'h42, 8'h24, 8'h99, 24'h5AA5F0);
        t_busy_write();
        summary();
    end
endmodule